// File: doc/BRIEF.md
# Speculative Register and Store Checkpoint Unit

This block holds the architectural state for a run of translated code that may have to be undone. Each register exists twice: a working value that instructions read and write, and a shadow value holding the last committed state. Stores are not sent to memory when they execute. They wait in a small ordered buffer, and loads look in that buffer before they use memory data.

At the end of a translated block a one-cycle commit pulse copies every working register into its shadow and marks all buffered stores as released. Released stores then drain to a plain memory write port, oldest first. If an exception occurs, a rollback pulse returns every working register to its shadow value and throws away the stores that were not yet released. The state is then exact at the block boundary, and execution can restart there.

Top module: `spec_state_ckpt`

## Requirements
- R1: `rd_data_o` shows the working value of register `rd_addr_i` combinationally. A write updates only the bytes whose `wr_be_i` bit is set (bit k covers data bits 8k+7..8k). Other bytes keep their old value, and the new value is visible from the next cycle.
- R2: An accepted store never reaches the memory port unless a commit without rollback has released it. With no released store pending, `mem_we_o` stays low.
- R3: For `ld_addr_i`, `ld_hit_o` is high when any buffered store, released or not, has that address. `ld_data_o` then carries buffered data. When there is no match, `ld_data_o` equals `ld_mem_data_i`.
- R4: When several buffered stores match a load address, the most recently accepted one supplies `ld_data_o`.
- R5: A commit copies every working register into its shadow in one cycle. A register write in the same cycle is included in the copy.
- R6: Released stores appear on `mem_we_o`/`mem_addr_o`/`mem_data_o` in acceptance order, one per cycle. The first appears in the cycle after the commit. `drain_busy_o` is high exactly while released stores remain.
- R7: A rollback returns every working register to its shadow value in the next cycle. A register write in the same cycle is dropped.
- R8: A rollback discards every unreleased store, including one presented in the same cycle. Stores already released keep draining.
- R9: `sb_full_o` is high when the buffer holds DEPTH entries. A store presented while full is ignored.
- R10: When commit and rollback are high together, the rollback happens and the commit is ignored.
- R11: After reset all registers read zero, the buffer is empty, and `sb_full_o`, `drain_busy_o`, `mem_we_o` and `ld_hit_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_i | input | IDX_W | Register read index |
| rd_data_o | output | DATA_W | Working value of the indexed register |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | IDX_W | Register write index |
| wr_be_i | input | DATA_W/8 | Byte enables for the write |
| wr_data_i | input | DATA_W | Register write data |
| st_en_i | input | 1 | Speculative store strobe |
| st_addr_i | input | ADDR_W | Store address |
| st_data_i | input | DATA_W | Store data |
| ld_addr_i | input | ADDR_W | Load address to search |
| ld_mem_data_i | input | DATA_W | Memory data for the load address |
| ld_data_o | output | DATA_W | Forwarded or memory load data |
| ld_hit_o | output | 1 | Load matched a buffered store |
| commit_i | input | 1 | Block commit pulse |
| rollback_i | input | 1 | Block rollback pulse |
| sb_full_o | output | 1 | Store buffer full |
| drain_busy_o | output | 1 | Released stores still pending |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | DATA_W | Memory write data |

## Verification
The bench builds the block with four registers, a four-entry store buffer and a 4-bit address space. A handful of random stores then fills the buffer, and repeated addresses are frequent enough to exercise youngest-match forwarding. Loads often overlap stores that are still draining. Random mixes of commit, rollback and both together land while the buffer holds a mix of released and unreleased entries, which tests the rollback split that keeps released stores draining.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  typedef enum logic [1:0] {
    CK_HOLD     = 2'd0,
    CK_COMMIT   = 2'd1,
    CK_ROLLBACK = 2'd2
  } ckpt_op_e;
endpackage

// File: rtl/ckpt_regfile.sv
module ckpt_regfile
  import ckpt_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int BE_W    = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ckpt_op_e          op_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [BE_W-1:0]   wr_be_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] work_vec [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] work_q, shad_q, work_nx;

    always_comb begin
      work_nx = work_q;
      if (wr_en_i && wr_addr_i == IDX_W'(g)) begin
        for (int b = 0; b < BE_W; b++) begin
          if (wr_be_i[b]) work_nx[8*b +: 8] = wr_data_i[8*b +: 8];
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        work_q <= '0;
        shad_q <= '0;
      end else begin
        case (op_i)
          CK_ROLLBACK: work_q <= shad_q;
          CK_COMMIT: begin
            work_q <= work_nx;
            shad_q <= work_nx;
          end
          default: work_q <= work_nx;
        endcase
      end
    end

    assign work_vec[g] = work_q;
  end

  assign rd_data_o = work_vec[rd_addr_i];
endmodule

// File: rtl/ckpt_store_buf.sv
module ckpt_store_buf
  import ckpt_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ckpt_op_e          op_i,
  input  logic              st_en_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic              fwd_hit_o,
  output logic [DATA_W-1:0] fwd_data_o,
  output logic              full_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q, scan_idx;
  logic [CNT_W-1:0]  count_q, rel_q, count_nx;
  logic              push, pop;

  assign full_o   = (count_q == CNT_W'(DEPTH));
  assign pop      = (rel_q != '0);
  assign push     = st_en_i && !full_o && (op_i != CK_ROLLBACK);
  assign count_nx = count_q + CNT_W'(push) - CNT_W'(pop);

  always_ff @(posedge clk_i) begin
    if (push) begin
      addr_q[tail_q] <= st_addr_i;
      data_q[tail_q] <= st_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      rel_q   <= '0;
    end else begin
      head_q <= head_q + PTR_W'(pop);
      case (op_i)
        CK_ROLLBACK: begin
          // keep only released entries; tail snaps behind them
          count_q <= rel_q - CNT_W'(pop);
          rel_q   <= rel_q - CNT_W'(pop);
          tail_q  <= head_q + rel_q[PTR_W-1:0];
        end
        CK_COMMIT: begin
          count_q <= count_nx;
          rel_q   <= count_nx;
          tail_q  <= tail_q + PTR_W'(push);
        end
        default: begin
          count_q <= count_nx;
          rel_q   <= rel_q - CNT_W'(pop);
          tail_q  <= tail_q + PTR_W'(push);
        end
      endcase
    end
  end

  // oldest to youngest; a later match overrides an earlier one
  always_comb begin
    fwd_hit_o  = 1'b0;
    fwd_data_o = '0;
    scan_idx   = head_q;
    for (int i = 0; i < DEPTH; i++) begin
      scan_idx = head_q + PTR_W'(i);
      if (CNT_W'(i) < count_q && addr_q[scan_idx] == ld_addr_i) begin
        fwd_hit_o  = 1'b1;
        fwd_data_o = data_q[scan_idx];
      end
    end
  end

  assign busy_o     = pop;
  assign mem_we_o   = pop;
  assign mem_addr_o = addr_q[head_q];
  assign mem_data_o = data_q[head_q];
endmodule

// File: rtl/spec_state_ckpt.sv
module spec_state_ckpt
  import ckpt_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int SB_DEPTH = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int BE_W    = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [BE_W-1:0]   wr_be_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              st_en_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_mem_data_i,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_hit_o,
  input  logic              commit_i,
  input  logic              rollback_i,
  output logic              sb_full_o,
  output logic              drain_busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  ckpt_op_e          op;
  logic [DATA_W-1:0] fwd_data;

  // rollback outranks commit
  assign op = rollback_i ? CK_ROLLBACK : (commit_i ? CK_COMMIT : CK_HOLD);

  ckpt_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rf (
    .clk_i, .rst_ni, .op_i(op),
    .wr_en_i, .wr_addr_i, .wr_be_i, .wr_data_i,
    .rd_addr_i, .rd_data_o
  );

  ckpt_store_buf #(.DEPTH(SB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sb (
    .clk_i, .rst_ni, .op_i(op),
    .st_en_i, .st_addr_i, .st_data_i,
    .ld_addr_i,
    .fwd_hit_o(ld_hit_o), .fwd_data_o(fwd_data),
    .full_o(sb_full_o), .busy_o(drain_busy_o),
    .mem_we_o, .mem_addr_o, .mem_data_o
  );

  assign ld_data_o = ld_hit_o ? fwd_data : ld_mem_data_i;
endmodule

// File: rtl/ckpt_checker.sv
module ckpt_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              commit_i,
  input logic              rollback_i,
  input logic              sb_full_o,
  input logic              drain_busy_o,
  input logic              mem_we_o,
  input logic              ld_hit_o,
  input logic [DATA_W-1:0] ld_data_o,
  input logic [DATA_W-1:0] ld_mem_data_i
);
  assert_mem_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !drain_busy_o) |=> !mem_we_o);

  assert_miss_uses_mem_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_hit_o |-> (ld_data_o == ld_mem_data_i));

  assert_drain_after_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drain_busy_o) |-> $past(commit_i && !rollback_i));

  assert_rollback_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rollback_i && !drain_busy_o) |=> !sb_full_o);

  assert_full_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sb_full_o && !drain_busy_o && !rollback_i) |=> sb_full_o);

  assert_rollback_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rollback_i && commit_i && !drain_busy_o) |=> !drain_busy_o);
endmodule

bind spec_state_ckpt ckpt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .commit_i, .rollback_i, .sb_full_o, .drain_busy_o,
  .mem_we_o, .ld_hit_o, .ld_data_o, .ld_mem_data_i
);

// File: tb/spec_state_ckpt_bench.sv
`timescale 1ns/1ps
module spec_state_ckpt_bench;
  localparam int NR = 4, DW = 32, AW = 4, SD = 4, IW = 2, BW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [IW-1:0] rd_addr_i = '0, wr_addr_i = '0;
  logic [DW-1:0] rd_data_o, wr_data_i = '0, st_data_i = '0, ld_mem_data_i = '0;
  logic [DW-1:0] ld_data_o, mem_data_o;
  logic [BW-1:0] wr_be_i = '0;
  logic [AW-1:0] st_addr_i = '0, ld_addr_i = '0, mem_addr_o;
  logic wr_en_i = 0, st_en_i = 0, commit_i = 0, rollback_i = 0;
  logic ld_hit_o, sb_full_o, drain_busy_o, mem_we_o;

  always #2 clk_i = ~clk_i;

  spec_state_ckpt #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW), .SB_DEPTH(SD)) u_spec_state_ckpt (.*);

  int n_chk = 0, n_bad = 0;
  string tag = "";
  logic [DW-1:0] mw [NR], ms [NR], md [SD];
  logic [AW-1:0] ma [SD];
  int mn = 0, mc = 0;

  function automatic string pick(string dflt);
    return (tag == "") ? dflt : tag;
  endfunction

  task automatic chk(string t, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", t, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic hit; logic [DW-1:0] fd;
    hit = 1'b0; fd = ld_mem_data_i;
    for (int i = 0; i < mn; i++) if (ma[i] == ld_addr_i) begin hit = 1'b1; fd = md[i]; end
    chk(pick("R1"), "rd_data", rd_data_o, mw[rd_addr_i]);
    chk(pick("R3"), "ld_hit", 32'(ld_hit_o), 32'(hit));
    chk(pick("R4"), "ld_data", ld_data_o, fd);
    chk(pick("R2"), "mem_we", 32'(mem_we_o), 32'(mc > 0));
    if (mc > 0) begin
      chk(pick("R6"), "mem_addr", 32'(mem_addr_o), 32'(ma[0]));
      chk(pick("R6"), "mem_data", mem_data_o, md[0]);
    end
    chk(pick("R9"), "full", 32'(sb_full_o), 32'(mn == SD));
    chk(pick("R6"), "busy", 32'(drain_busy_o), 32'(mc > 0));
  endtask

  task automatic model_edge();
    logic [DW-1:0] nx;
    logic pop, push;
    pop  = (mc > 0);
    push = st_en_i && (mn < SD) && !rollback_i;
    if (rollback_i) begin
      for (int r = 0; r < NR; r++) mw[r] = ms[r];
    end else begin
      if (wr_en_i) begin
        nx = mw[wr_addr_i];
        for (int b = 0; b < BW; b++) if (wr_be_i[b]) nx[8*b +: 8] = wr_data_i[8*b +: 8];
        mw[wr_addr_i] = nx;
      end
      if (commit_i) for (int r = 0; r < NR; r++) ms[r] = mw[r];
    end
    if (pop) begin
      for (int i = 0; i < SD - 1; i++) begin ma[i] = ma[i+1]; md[i] = md[i+1]; end
      mn--; mc--;
    end
    if (rollback_i) mn = mc;
    else begin
      if (push) begin ma[mn] = st_addr_i; md[mn] = st_data_i; mn++; end
      if (commit_i) mc = mn;
    end
  endtask

  task automatic step();
    #1 check_all();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    wr_en_i = 0; st_en_i = 0; commit_i = 0; rollback_i = 0;
  endtask

  task automatic store(logic [AW-1:0] a, logic [DW-1:0] d);
    st_en_i = 1; st_addr_i = a; st_data_i = d; step();
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int r = 0; r < NR; r++) begin mw[r] = '0; ms[r] = '0; end
    for (int i = 0; i < SD; i++) begin ma[i] = '0; md[i] = '0; end
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    tag = "R11";
    for (int r = 0; r < NR; r++) begin rd_addr_i = IW'(r); #1 check_all(); end
    @(negedge clk_i);

    tag = "R1";
    wr_en_i = 1; wr_addr_i = 1; wr_be_i = 4'hF; wr_data_i = 32'hAABBCCDD; step();
    wr_en_i = 1; wr_addr_i = 1; wr_be_i = 4'h1; wr_data_i = 32'h00000011; rd_addr_i = 1; step();
    step();
    chk("R1", "partial write", rd_data_o, 32'hAABBCC11);

    tag = "R2";
    store(4'd3, 32'h12345678);
    repeat (3) step();

    tag = "R3";
    ld_addr_i = 3; step();
    ld_addr_i = 5; ld_mem_data_i = 32'hCAFE0005; step();

    tag = "R4";
    store(4'd3, 32'h87654321);
    ld_addr_i = 3; step();
    chk("R4", "youngest fwd", ld_data_o, 32'h87654321);

    tag = "R5";
    commit_i = 1; wr_en_i = 1; wr_addr_i = 2; wr_be_i = 4'hF; wr_data_i = 32'h55; step();
    tag = "R6";
    repeat (3) step();

    tag = "R7";
    wr_en_i = 1; wr_addr_i = 2; wr_be_i = 4'hF; wr_data_i = 32'h66; step();
    wr_en_i = 1; wr_addr_i = 2; wr_be_i = 4'hF; wr_data_i = 32'h77; rollback_i = 1; rd_addr_i = 2; step();
    step();
    chk("R5", "shadow after commit", rd_data_o, 32'h55);

    tag = "R8";
    store(4'd1, 32'h1111);
    st_en_i = 1; st_addr_i = 2; st_data_i = 32'h2222; rollback_i = 1; step();
    ld_addr_i = 1; step();
    chk("R8", "discarded hit", 32'(ld_hit_o), 32'h0);

    tag = "R9";
    for (int i = 0; i < SD + 1; i++) store(AW'(8 + i), 32'hF000 + DW'(i));
    ld_addr_i = AW'(8 + SD); step();
    chk("R9", "ignored store hit", 32'(ld_hit_o), 32'h0);
    rollback_i = 1; step();

    tag = "R10";
    store(4'd6, 32'h6666);
    commit_i = 1; rollback_i = 1; step();
    ld_addr_i = 6; step();
    chk("R10", "busy after both", 32'(drain_busy_o), 32'h0);

    tag = "";
    for (int n = 0; n < 4000; n++) begin
      rd_addr_i = IW'($urandom);
      wr_en_i = ($urandom % 2) == 0; wr_addr_i = IW'($urandom);
      wr_be_i = BW'($urandom); wr_data_i = $urandom;
      st_en_i = ($urandom % 5) < 2; st_addr_i = AW'($urandom); st_data_i = $urandom;
      ld_addr_i = AW'($urandom); ld_mem_data_i = $urandom;
      commit_i = ($urandom % 10) == 0; rollback_i = ($urandom % 16) == 0;
      step();
    end
    finish_run();
  end
endmodule